// File: doc/BRIEF.md
# DRAM Impedance Calibration Scheduler

This controller-side block decides when to send long and short impedance-calibration commands to a DDR3-class memory. It then holds off all other command traffic until the memory's calibration window has elapsed. After reset and device initialization, a start pulse asks for the first calibration, which is always a long one and uses the long initialization window. When that window ends, the block raises a sticky done flag. From then on, a periodic tick asks for short calibrations, and a separate request can ask for a long calibration at any time. A long calibration issued after the done flag is set uses the shorter operational window.

A command goes out only in a cycle after the rest of the controller has reported idle, meaning no operation is in flight and all banks are closed. A request that arrives while a window is running is kept pending. It is served once the window has run out. When long and short requests are both pending, the long one goes first. Every window length is a parameter counted in clock cycles.

Top module: `zq_cal_sched`

## Requirements
- R1: The first command after reset is a long calibration, triggered only by `start_i`. `short_req_i` and `long_req_i` have no effect while `init_done_o` is low.
- R2: A long calibration issued while `init_done_o` is low holds `block_o` high for exactly `INIT_WIN` cycles, counted from the command cycle.
- R3: A long calibration issued after `init_done_o` is high holds `block_o` high for exactly `OPER_WIN` cycles, counted from the command cycle.
- R4: A short calibration holds `block_o` high for exactly `SHORT_WIN` cycles (default 64). No command is issued while `block_o` is high.
- R5: Once `init_done_o` is high, a pulse on `long_req_i` always leads to a long calibration command (`cmd_long_o` = 1).
- R6: A command is issued only in the cycle after a clock edge at which `idle_i` was high and no window was running. While `idle_i` is low, pending requests wait.
- R7: A request that arrives during a running window is kept, not dropped. It is issued in the second cycle after `block_o` falls, provided `idle_i` is high.
- R8: When both a long and a short request are pending, the long calibration is issued first and the short one after its window.
- R9: `init_done_o` rises in the same cycle that `block_o` falls at the end of the first long window. It then stays high until reset. `start_i` pulses after the first calibration has been issued are ignored.
- R10: `cmd_vld_o` is a single-cycle strobe. `cmd_long_o` is 1 for a long calibration and 0 for a short one. After reset, `cmd_vld_o`, `block_o` and `init_done_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Pulse after initialization asking for the first long calibration |
| short_req_i | input | 1 | Periodic short-calibration request tick |
| long_req_i | input | 1 | Long-calibration request after initialization |
| idle_i | input | 1 | Controller has no operation in flight and all banks are idle |
| cmd_vld_o | output | 1 | One-cycle calibration command strobe |
| cmd_long_o | output | 1 | Command kind when strobed: 1 long, 0 short |
| block_o | output | 1 | All other commands must be held off |
| init_done_o | output | 1 | Sticky flag: first long calibration window has finished |

## Verification
The assertions check several properties on every cycle:
- any command issued before the done flag is long;
- every strobe follows a cycle in which `idle_i` was high;
- no window is reloaded while one is still running;
- `block_o` covers the strobe cycle and drops right after expiry;
- pending flags persist until they are served;
- the done flag never falls.

The exact lengths of the three windows, the choice between init and operational windows, and the ordering of long before short can only be shown by the bench scenarios. The same holds for the one-cycle gap after a window and for ignored requests before initialization.

// File: rtl/zq_cal_pkg.sv
package zq_cal_pkg;
  localparam int ZQ_NUM_SRC = 3;
  // index order is grant priority
  typedef enum int unsigned {
    ZQ_SRC_INIT  = 0,
    ZQ_SRC_LONG  = 1,
    ZQ_SRC_SHORT = 2
  } zq_src_e;
endpackage

// File: rtl/zq_pend_flag.sv
module zq_pend_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  logic pend_q;

  // a set in the clear cycle wins: the new request is kept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign pend_o = pend_q;

  AST_PEND_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o && !clr_i |=> pend_o); // R7
endmodule

// File: rtl/zq_win_timer.sv
module zq_win_timer #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          busy_o,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o   = (cnt_q != '0);
  assign expire_o = (cnt_q == CW'(1));

  AST_NO_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !busy_o); // R4
  AST_EXPIRE_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o && !load_i |=> !busy_o); // R4
endmodule

// File: rtl/zq_cal_sched.sv
module zq_cal_sched
  import zq_cal_pkg::*;
#(
  parameter int INIT_WIN  = 512,
  parameter int OPER_WIN  = 256,
  parameter int SHORT_WIN = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic short_req_i,
  input  logic long_req_i,
  input  logic idle_i,
  output logic cmd_vld_o,
  output logic cmd_long_o,
  output logic block_o,
  output logic init_done_o
);
  localparam int MAX_LW  = (INIT_WIN > OPER_WIN) ? INIT_WIN : OPER_WIN;
  localparam int MAX_WIN = (MAX_LW > SHORT_WIN) ? MAX_LW : SHORT_WIN;
  localparam int CW      = $clog2(MAX_WIN + 1);

  logic [ZQ_NUM_SRC-1:0] set_v, pend_v, grant_v, clr_v;
  logic                  busy, expire, launch;
  logic [CW-1:0]         load_val;
  logic                  cmd_vld_q, cmd_long_q;
  logic                  init_launched_q, win_init_q, init_done_q;

  // request gating: before init only the start pulse counts
  assign set_v[ZQ_SRC_INIT]  = start_i & ~init_launched_q;
  assign set_v[ZQ_SRC_LONG]  = long_req_i & init_done_q;
  assign set_v[ZQ_SRC_SHORT] = short_req_i & init_done_q;

  for (genvar g = 0; g < ZQ_NUM_SRC; g++) begin : g_pend
    zq_pend_flag u_pend (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_v[g]),
      .clr_i  (clr_v[g]),
      .pend_o (pend_v[g])
    );
  end

  // fixed priority, lowest index first
  always_comb begin
    grant_v = '0;
    for (int i = 0; i < ZQ_NUM_SRC; i++) begin
      if (pend_v[i] && grant_v == '0) grant_v[i] = 1'b1;
    end
  end

  assign launch = idle_i & ~busy & (|pend_v);
  assign clr_v  = grant_v & {ZQ_NUM_SRC{launch}};

  always_comb begin
    if (grant_v[ZQ_SRC_INIT])      load_val = CW'(INIT_WIN);
    else if (grant_v[ZQ_SRC_LONG]) load_val = CW'(OPER_WIN);
    else                           load_val = CW'(SHORT_WIN);
  end

  zq_win_timer #(.CW(CW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (launch),
    .load_val_i (load_val),
    .busy_o     (busy),
    .expire_o   (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_vld_q       <= 1'b0;
      cmd_long_q      <= 1'b0;
      init_launched_q <= 1'b0;
      win_init_q      <= 1'b0;
      init_done_q     <= 1'b0;
    end else begin
      cmd_vld_q  <= launch;
      cmd_long_q <= launch & ~grant_v[ZQ_SRC_SHORT];
      if (launch) win_init_q <= grant_v[ZQ_SRC_INIT];
      if (launch && grant_v[ZQ_SRC_INIT]) init_launched_q <= 1'b1;
      if (expire && win_init_q)           init_done_q     <= 1'b1;
    end
  end

  assign cmd_vld_o   = cmd_vld_q;
  assign cmd_long_o  = cmd_long_q;
  assign block_o     = busy;
  assign init_done_o = init_done_q;

  AST_FIRST_LONG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_vld_o && !init_done_o |-> cmd_long_o); // R1
  AST_IDLE_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_vld_o |-> $past(idle_i)); // R6
  AST_BLOCK_ON_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_vld_o |-> block_o); // R4
  AST_SINGLE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_vld_o |=> !cmd_vld_o); // R10
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o); // R9
endmodule

// File: tb/zq_cal_sched_tb.sv
module zq_cal_sched_tb_top;
  localparam int INIT_WIN  = 20;
  localparam int OPER_WIN  = 10;
  localparam int SHORT_WIN = 64;

  // req: 0 start, 1 long, 2 short
  typedef struct packed {
    logic [1:0] req;
    logic [3:0] hold;
    logic       exp_cmd;
    logic       exp_long;
    logic [7:0] exp_win;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    {2'd0, 4'd0, 1'b1, 1'b1, 8'd20},
    {2'd2, 4'd0, 1'b1, 1'b0, 8'd64},
    {2'd1, 4'd3, 1'b1, 1'b1, 8'd10},
    {2'd2, 4'd5, 1'b1, 1'b0, 8'd64},
    {2'd1, 4'd0, 1'b1, 1'b1, 8'd10},
    {2'd0, 4'd0, 1'b0, 1'b0, 8'd0}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, short_req_i = 1'b0, long_req_i = 1'b0, idle_i = 1'b1;
  logic cmd_vld_o, cmd_long_o, block_o, init_done_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #4 clk_i = ~clk_i;

  zq_cal_sched #(.INIT_WIN(INIT_WIN), .OPER_WIN(OPER_WIN), .SHORT_WIN(SHORT_WIN)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .short_req_i(short_req_i),
    .long_req_i(long_req_i), .idle_i(idle_i), .cmd_vld_o(cmd_vld_o),
    .cmd_long_o(cmd_long_o), .block_o(block_o), .init_done_o(init_done_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse(input int req);
    case (req)
      0: start_i = 1'b1;
      1: long_req_i = 1'b1;
      default: short_req_i = 1'b1;
    endcase
    @(negedge clk_i);
    start_i = 1'b0; long_req_i = 1'b0; short_req_i = 1'b0;
  endtask

  // wait for strobe, return kind and block length from the strobe cycle
  task automatic wait_cmd(output bit got, output bit lng, output int win, output bit done_in);
    got = 1'b0; lng = 1'b0; win = 0; done_in = 1'b0;
    for (int i = 0; i < 30; i++) begin
      if (cmd_vld_o) begin got = 1'b1; break; end
      @(negedge clk_i);
    end
    if (got) begin
      lng = cmd_long_o;
      done_in = init_done_o;
      while (block_o) begin
        win++;
        @(negedge clk_i);
      end
    end
  endtask

  initial begin
    bit got, lng, early, done_in;
    int win;
    vec_t v;
    repeat (3) @(negedge clk_i);
    chk(!cmd_vld_o && !block_o && !init_done_o, "R10 reset state", int'(init_done_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!cmd_vld_o && !block_o && !init_done_o, "R10 after reset", int'(block_o), 0);

    // R1: requests before init are ignored
    pulse(2);
    pulse(1);
    wait_cmd(got, lng, win, done_in);
    chk(!got, "R1 pre-init requests ignored", int'(got), 0);

    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      early = 1'b0;
      if (v.hold != 0) idle_i = 1'b0;
      pulse(int'(v.req));
      for (int h = 0; h < int'(v.hold); h++) begin
        if (cmd_vld_o) early = 1'b1;
        @(negedge clk_i);
      end
      if (cmd_vld_o) early = 1'b1;
      idle_i = 1'b1;
      wait_cmd(got, lng, win, done_in);
      chk(!early, "R6 no command while busy reported", int'(early), 0);
      chk(got == v.exp_cmd, "R9 R5 command presence", int'(got), int'(v.exp_cmd));
      if (v.exp_cmd) begin
        chk(lng == v.exp_long, "R10 R5 command kind", int'(lng), int'(v.exp_long));
        chk(win == int'(v.exp_win), "R2 R3 R4 window length", win, int'(v.exp_win));
      end
      if (i == 0) begin
        chk(!done_in, "R9 done low during first window", int'(done_in), 0);
        chk(init_done_o, "R9 done rises with block fall", int'(init_done_o), 1);
      end
    end

    // R7: short request during long window is held and served
    pulse(1);
    for (int i = 0; i < 5 && !cmd_vld_o; i++) @(negedge clk_i);
    chk(cmd_vld_o && cmd_long_o, "R7 long issued", int'(cmd_long_o), 1);
    @(negedge clk_i);
    chk(!cmd_vld_o, "R10 strobe one cycle", int'(cmd_vld_o), 0);
    pulse(2);
    while (block_o) @(negedge clk_i);
    chk(!cmd_vld_o, "R7 gap cycle after window", int'(cmd_vld_o), 0);
    @(negedge clk_i);
    chk(cmd_vld_o && !cmd_long_o, "R7 pending short served", int'(cmd_vld_o), 1);
    while (block_o) @(negedge clk_i);

    // R8: long ahead of short when both pending
    idle_i = 1'b0;
    pulse(2);
    pulse(1);
    repeat (2) @(negedge clk_i);
    chk(!cmd_vld_o, "R6 held while not idle", int'(cmd_vld_o), 0);
    idle_i = 1'b1;
    wait_cmd(got, lng, win, done_in);
    chk(got && lng && win == OPER_WIN, "R8 long first", win, OPER_WIN);
    wait_cmd(got, lng, win, done_in);
    chk(got && !lng && win == SHORT_WIN, "R8 short second", win, SHORT_WIN);
    chk(init_done_o, "R9 done sticky", int'(init_done_o), 1);

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule